// File: doc/BRIEF.md
# Ternary-by-Integer Circular Polynomial Convolver

This block multiplies a polynomial whose coefficients are -1, 0 or +1 by a polynomial with 11-bit integer coefficients. The product is taken modulo x^N - 1, and every coefficient wraps modulo 2048. Both operands are written one coefficient at a time into an operand bank while the block is idle. A start pulse then runs the product. N add/subtract/hold units sit around a ring of N accumulator registers. In every cycle a single ternary coefficient is broadcast to all units. Unit i combines its fixed integer operand B_i with accumulator i and writes the result one place down the ring. One complete pass over the ternary polynomial is a round of N cycles.

Two modes share the same datapath. The plain product mode runs one round. The key-combination mode computes (1 + 3A) * B, the form used when a secret key is built as one plus three times a ternary polynomial. It accumulates A * B three times without clearing the ring. It then adds B, either through a fourth round driven by a unit impulse or by seeding the ring with B at start. Every ternary coefficient costs one cycle whatever its value, so the run time depends only on the mode and never on the operand data. Once a run has finished, any result coefficient can be read by index.

Top module: `tcv_conv`

## Requirements
- R1: Every accumulator and operand coefficient is 11 bits wide, and each addition or subtraction wraps modulo 2048 by dropping the carry or borrow.
- R2: A ternary coefficient is coded in 2 bits: 2'b00 is zero, 2'b01 is +1, 2'b11 is -1, and 2'b10 is handled exactly like zero.
- R3: With `mode_dec`=0 and `preload`=0, a start clears the accumulator. After the run, coefficient j holds the sum over k of A_k * B_((j-k) mod N), modulo 2048.
- R4: Ternary coefficients are consumed one per cycle starting at A_0, and a zero takes a full cycle. A run lasts exactly N cycles per round, regardless of the ternary values.
- R5: With `mode_dec`=1 and `preload`=0, the accumulator is cleared and four rounds (4N cycles) are run: three with A and one with an impulse at index 0. The result is 3*(A*B) + B modulo 2048.
- R6: With `preload`=1, a start copies B into the accumulator instead of clearing it. Mode 0 then gives A*B + B after N cycles, and mode 1 gives 3*(A*B) + B after 3N cycles.
- R7: `busy` is high from the cycle after an accepted start until the last round has completed. `done` is high for exactly one cycle, the cycle right after the final accumulation edge. When a start is sampled on clock edge e, `done` is observed after edge e + rounds*N.
- R8: A start pulse that arrives while `busy` is high is ignored: the running product's mode, length and result are unchanged.
- R9: Operand writes through `ld_we` that arrive while `busy` is high are ignored and do not alter the result of the run in progress.
- R10: After reset, `busy` and `done` are low and every accumulator coefficient reads 0.
- R11: `rd_coef` shows accumulator coefficient `rd_idx` without a clock delay. The result stays unchanged after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a product when idle |
| mode_dec | input | 1 | 0: plain product, 1: (1+3A)*B |
| preload | input | 1 | Seed the accumulator with B instead of clearing it |
| ld_we | input | 1 | Operand write strobe (idle only) |
| ld_idx | input | $clog2(N) | Coefficient index for the operand write |
| ld_tern | input | 2 | Ternary coefficient A at ld_idx |
| ld_coef | input | 11 | Integer coefficient B at ld_idx |
| rd_idx | input | $clog2(N) | Result coefficient index |
| rd_coef | output | 11 | Result coefficient at rd_idx |
| busy | output | 1 | Product in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- An all-zero ternary operand must take the same number of cycles as a dense one; a design that skipped zeros would finish early.
- A lone -1 at the top index checks the wrap of the ring. A ring rotating the wrong way would put the product at mirrored indices.
- Operands near 2047 combined with all-ones A force carries; wider or saturating arithmetic would give different sums.
- Code 10 is mixed into A; treating it as -1 would corrupt the result.
- Start pulses and operand writes injected mid-run must leave the latency and result intact. A design that honoured them would restart, change mode or mix new operands into the sum.

// File: rtl/tcv_pkg.sv
package tcv_pkg;
  localparam int COEF_W = 11;

  typedef enum logic [1:0] {
    TRN_ZERO = 2'b00,
    TRN_POS  = 2'b01,
    TRN_RSV  = 2'b10,
    TRN_NEG  = 2'b11
  } trn_t;
endpackage

// File: rtl/tcv_mau.sv
module tcv_mau
  import tcv_pkg::*;
#(
  parameter int W = COEF_W
) (
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opd_in,
  input  trn_t         op,
  output logic [W-1:0] acc_out
);
  // Width-W arithmetic wraps modulo 2**W (R1)
  always_comb begin
    unique case (op)
      TRN_POS: acc_out = acc_in + opd_in;
      TRN_NEG: acc_out = acc_in - opd_in;
      default: acc_out = acc_in;
    endcase
  end
endmodule

// File: rtl/tcv_opbank.sv
module tcv_opbank
  import tcv_pkg::*;
#(
  parameter int N  = 16,
  parameter int W  = COEF_W,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_trn,
  input  logic [W-1:0]  wr_opd,
  input  logic [IW-1:0] sel_idx,
  output trn_t          sel_trn,
  output logic [N*W-1:0] opd_flat
);
  logic [1:0]   trn_q [N];
  logic [W-1:0] opd_q [N];
  logic         wr_ok;

  assign wr_ok = wr_en && !busy;

  generate
    for (genvar i = 0; i < N; i++) begin : g_slot
      logic hit;
      assign hit = wr_ok && (int'(wr_idx) == i);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          trn_q[i] <= 2'b00;
          opd_q[i] <= '0;
        end else if (hit) begin
          trn_q[i] <= wr_trn;
          opd_q[i] <= wr_opd;
        end
      end

      assign opd_flat[i*W +: W] = opd_q[i];

      // Operand bank frozen during a run (R9)
      assert_load_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(opd_q[i]) && $stable(trn_q[i])));
    end
  endgenerate

  always_comb begin
    sel_trn = TRN_ZERO;
    for (int k = 0; k < N; k++) begin
      if (int'(sel_idx) == k) sel_trn = trn_t'(trn_q[k]);
    end
  end
endmodule

// File: rtl/tcv_ring.sv
module tcv_ring
  import tcv_pkg::*;
#(
  parameter int N = 16,
  parameter int W = COEF_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_clr,
  input  logic           acc_seed,
  input  logic           step_en,
  input  trn_t           op,
  input  logic [N*W-1:0] opd_flat,
  output logic [N*W-1:0] acc_flat
);
  logic [W-1:0] acc_q   [N];
  logic [W-1:0] acc_rot [N];
  logic [W-1:0] acc_nx  [N];
  logic [W-1:0] unit_out[N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      localparam int DST = (i + N - 1) % N;

      tcv_mau #(.W(W)) u_mau (
        .acc_in (acc_q[i]),
        .opd_in (opd_flat[i*W +: W]),
        .op     (op),
        .acc_out(unit_out[i])
      );

      // Unit i feeds the register one place down the ring
      assign acc_rot[DST] = unit_out[i];

      always_comb begin
        if (acc_clr)       acc_nx[i] = '0;
        else if (acc_seed) acc_nx[i] = opd_flat[i*W +: W];
        else               acc_nx[i] = acc_rot[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            acc_q[i] <= '0;
        else if (acc_clr || acc_seed || step_en) acc_q[i] <= acc_nx[i];
      end

      assign acc_flat[i*W +: W] = acc_q[i];

      // A zero (or reserved) coefficient only rotates the ring (R2, R4)
      assert_zero_rotates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && (op == TRN_ZERO || op == TRN_RSV)) |=> (acc_q[DST] == $past(acc_q[i])));

      // Clear at start gives an all-zero accumulator (R3)
      assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_q[i] == '0));

      // Seeding copies the integer operand (R6)
      assert_seed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_seed |=> (acc_q[i] == $past(opd_flat[i*W +: W])));

      // Result holds while idle (R11)
      assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !acc_clr && !acc_seed) |=> $stable(acc_q[i]));
    end
  endgenerate
endmodule

// File: rtl/tcv_ctrl.sv
module tcv_ctrl
  import tcv_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_dec,
  input  logic          preload,
  input  trn_t          bank_trn,
  output logic [IW-1:0] cur_idx,
  output trn_t          op,
  output logic          step_en,
  output logic          acc_clr,
  output logic          acc_seed,
  output logic          busy,
  output logic          done
);
  localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          mode_q, mode_d;
  logic          pre_q,  pre_d;
  logic [IW-1:0] cnt_q,  cnt_d;
  logic [1:0]    rnd_q,  rnd_d;
  logic [1:0]    last_rnd;
  logic          accept;
  logic          impulse_rnd;

  assign accept   = start && !busy_q;
  assign last_rnd = !mode_q ? 2'd0 : (pre_q ? 2'd2 : 2'd3);
  assign impulse_rnd = mode_q && !pre_q && (rnd_q == 2'd3);

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    mode_d = mode_q;
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    rnd_d  = rnd_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        mode_d = mode_dec;
        pre_d  = preload;
        cnt_d  = '0;
        rnd_d  = '0;
      end
    end else if (cnt_q == LAST_IDX) begin
      cnt_d = '0;
      if (rnd_q == last_rnd) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        rnd_d = rnd_q + 2'd1;
      end
    end else begin
      cnt_d = cnt_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= 1'b0;
      pre_q  <= 1'b0;
      cnt_q  <= '0;
      rnd_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (accept) begin
        mode_q <= mode_d;
        pre_q  <= pre_d;
      end
      if (accept || busy_q) begin
        cnt_q <= cnt_d;
        rnd_q <= rnd_d;
      end
    end
  end

  always_comb begin
    if (impulse_rnd) op = (cnt_q == '0) ? TRN_POS : TRN_ZERO;
    else             op = bank_trn;
  end

  assign cur_idx  = cnt_q;
  assign step_en  = busy_q;
  assign acc_clr  = accept && !preload;
  assign acc_seed = accept && preload;
  assign busy     = busy_q;
  assign done     = done_q;

  // Independent run-length counter for the latency check
  logic [31:0] chk_len;
  logic [31:0] chk_expect;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_len <= '0;
    else if (accept) chk_len <= '0;
    else if (busy_q) chk_len <= chk_len + 32'd1;
  end
  assign chk_expect = 32'(N) * (!mode_q ? 32'd1 : (pre_q ? 32'd3 : 32'd4));

  // Run length fixed by mode alone (R4, R5, R6)
  assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (chk_len == chk_expect));

  // done is a single-cycle pulse at the end of busy (R7)
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $fell(busy_q));

  // Start during a run does not change the latched mode (R8)
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(mode_q) && $stable(pre_q)));
endmodule

// File: rtl/tcv_conv.sv
module tcv_conv
  import tcv_pkg::*;
#(
  parameter int N  = 16,
  parameter int W  = COEF_W,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_dec,
  input  logic          preload,
  input  logic          ld_we,
  input  logic [IW-1:0] ld_idx,
  input  logic [1:0]    ld_tern,
  input  logic [W-1:0]  ld_coef,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_coef,
  output logic          busy,
  output logic          done
);
  logic [IW-1:0]  cur_idx;
  trn_t           bank_trn;
  trn_t           op;
  logic           step_en;
  logic           acc_clr;
  logic           acc_seed;
  logic [N*W-1:0] opd_flat;
  logic [N*W-1:0] acc_flat;

  tcv_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode_dec(mode_dec),
    .preload (preload),
    .bank_trn(bank_trn),
    .cur_idx (cur_idx),
    .op      (op),
    .step_en (step_en),
    .acc_clr (acc_clr),
    .acc_seed(acc_seed),
    .busy    (busy),
    .done    (done)
  );

  tcv_opbank #(.N(N), .W(W), .IW(IW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .wr_en   (ld_we),
    .wr_idx  (ld_idx),
    .wr_trn  (ld_tern),
    .wr_opd  (ld_coef),
    .sel_idx (cur_idx),
    .sel_trn (bank_trn),
    .opd_flat(opd_flat)
  );

  tcv_ring #(.N(N), .W(W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_clr (acc_clr),
    .acc_seed(acc_seed),
    .step_en (step_en),
    .op      (op),
    .opd_flat(opd_flat),
    .acc_flat(acc_flat)
  );

  always_comb begin
    rd_coef = '0;
    for (int k = 0; k < N; k++) begin
      if (int'(rd_idx) == k) rd_coef = acc_flat[k*W +: W];
    end
  end
endmodule

// File: tb/tcv_conv_tb.sv
module tcv_conv_tb;
  localparam int N  = 16;
  localparam int W  = 11;
  localparam int IW = $clog2(N);

  typedef struct packed {
    logic       mode;
    logic       pre;
    logic [2:0] apat;
    logic [7:0] bseed;
    logic [2:0] rounds;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 3'd2, 8'd3,  3'd1},
    '{1'b0, 1'b0, 3'd0, 8'd5,  3'd1},
    '{1'b0, 1'b0, 3'd1, 8'd0,  3'd1},
    '{1'b0, 1'b0, 3'd3, 8'd7,  3'd1},
    '{1'b1, 1'b0, 3'd2, 8'd9,  3'd4},
    '{1'b1, 1'b1, 3'd4, 8'd11, 3'd3},
    '{1'b0, 1'b1, 3'd4, 8'd0,  3'd1},
    '{1'b1, 1'b0, 3'd1, 8'd0,  3'd4}
  };

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          mode_dec;
  logic          preload;
  logic          ld_we;
  logic [IW-1:0] ld_idx;
  logic [1:0]    ld_tern;
  logic [W-1:0]  ld_coef;
  logic [IW-1:0] rd_idx;
  logic [W-1:0]  rd_coef;
  logic          busy;
  logic          done;

  int checks;
  int errors;
  bit finished;

  tcv_conv #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_dec(mode_dec),
    .preload(preload), .ld_we(ld_we), .ld_idx(ld_idx), .ld_tern(ld_tern),
    .ld_coef(ld_coef), .rd_idx(rd_idx), .rd_coef(rd_coef),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [1:0] gen_a(int pat, int k);
    case (pat)
      0: return 2'b00;
      1: return 2'b01;
      2: case (k % 4) 0: return 2'b01; 1: return 2'b00; 2: return 2'b11; default: return 2'b10; endcase
      3: return (k == N - 1) ? 2'b11 : 2'b00;
      default: return (k % 3 == 0) ? 2'b11 : 2'b01;
    endcase
  endfunction

  function automatic int gen_b(int seed, int i);
    if (seed == 0) return 2047 - i;
    return (seed * 37 + i * 211 + 5) % 2048;
  endfunction

  function automatic int tval(logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic int model(int mode, int pre, int pat, int seed, int j);
    int prod = 0;
    int r;
    for (int k = 0; k < N; k++) prod += tval(gen_a(pat, k)) * gen_b(seed, (j - k + N) % N);
    if (mode != 0)     r = 3 * prod + gen_b(seed, j);
    else if (pre != 0) r = prod + gen_b(seed, j);
    else               r = prod;
    r = r % 2048;
    if (r < 0) r += 2048;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load_ops(int pat, int seed);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_idx = IW'(i); ld_tern = gen_a(pat, i); ld_coef = W'(gen_b(seed, i));
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  // disturb: 0 none, 1 start mid-run, 2 operand write mid-run
  task automatic run_vec(int mode, int pre, int pat, int seed, int rounds, string req, int disturb);
    int cyc;
    int bad;
    int first_act;
    int first_exp;
    load_ops(pat, seed);
    @(negedge clk);
    start = 1'b1; mode_dec = mode[0]; preload = pre[0];
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 6 * N + 20) begin
      if (cyc == 3 && disturb == 1) begin start = 1'b1; mode_dec = ~mode_dec; preload = ~preload; end
      if (cyc == 3 && disturb == 2) begin ld_we = 1'b1; ld_idx = '0; ld_tern = 2'b11; ld_coef = 11'd1234; end
      if (cyc == 4) begin start = 1'b0; ld_we = 1'b0; end
      @(negedge clk);
      cyc++;
    end
    check(done === 1'b1 && cyc == rounds * N + 1, "R4/R7", "latency", cyc, rounds * N + 1);
    bad = 0; first_act = 0; first_exp = 0;
    for (int j = 0; j < N; j++) begin
      rd_idx = IW'(j);
      #1;
      if (int'(rd_coef) != model(mode, pre, pat, seed, j)) begin
        if (bad == 0) begin first_act = int'(rd_coef); first_exp = model(mode, pre, pat, seed, j); end
        bad++;
      end
    end
    check(bad == 0, req, "result coefficient", first_act, first_exp);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R7", "done pulse width", int'(done), 0);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; mode_dec = 1'b0; preload = 1'b0;
    ld_we = 1'b0; ld_idx = '0; ld_tern = 2'b00; ld_coef = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check(busy === 1'b0, "R10", "busy after reset", int'(busy), 0);
    check(done === 1'b0, "R10", "done after reset", int'(done), 0);
    begin
      int nz = 0;
      for (int j = 0; j < N; j++) begin
        rd_idx = IW'(j); #1;
        if (rd_coef !== '0) nz++;
      end
      check(nz == 0, "R10", "nonzero accumulator after reset", nz, 0);
    end

    // Vector table: R1 wrap, R2 encoding, R3 plain, R5 key mode, R6 preload
    for (int v = 0; v < NV; v++) begin
      string tag;
      if (VECS[v].pre)       tag = "R6";
      else if (VECS[v].mode) tag = "R5";
      else if (VECS[v].bseed == 0) tag = "R1";
      else if (VECS[v].apat == 2) tag = "R2";
      else tag = "R3";
      run_vec(int'(VECS[v].mode), int'(VECS[v].pre), int'(VECS[v].apat),
              int'(VECS[v].bseed), int'(VECS[v].rounds), tag, 0);
    end

    // R8: start pulse during a run is ignored
    run_vec(0, 0, 4, 13, 1, "R8", 1);
    // R9: operand write during a run is ignored
    run_vec(1, 0, 2, 17, 4, "R9", 2);

    // R11: result holds after done until next start
    begin
      int bad = 0;
      repeat (5) @(negedge clk);
      for (int j = 0; j < N; j++) begin
        rd_idx = IW'(j); #1;
        if (int'(rd_coef) != model(1, 0, 2, 17, j)) bad++;
      end
      check(bad == 0, "R11", "result hold mismatches", bad, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule